// File: doc/BRIEF.md
# Dual-Slot Receive Buffer Controller

This block is the register-side control core of a simple Ethernet MAC. Software reaches seven 32-bit registers at word offsets 0 to 6 over a single-cycle access port. Five of them matter to the frame flow: two receive slots, each with a state register and a count register, and a transmit count register. Two more hold PHY setup and the bit-banged management pins. The block does not hold frame data. It only tracks who owns each buffer slot.

Software arms a slot by writing LOADED to its state register. When the receive datapath signals that a frame has completed, the block gives the frame to the first armed slot, with slot 0 ahead of slot 1. It stores the byte count in that slot and marks the slot PENDING. A registered level interrupt then stays high while any slot is pending. If no slot is armed, the frame is dropped and no register changes.

A nonzero write to the transmit count register starts a length check. A legal length clears the register and an illegal one is left in place. Either way a one-cycle transmit interrupt follows.

Top module: `dual_slot_rx_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `rx_irq`, `tx_irq`, `acc_err`, `rx_ready` and `phy_reset` are low. Bit 1 of the management register is the one exception: it follows `mdio_in` from the first clock after reset.
- R2: Word offsets map to registers as follows: 0 = setup, 1 = management pins, 2 = slot-0 state, 3 = slot-0 count, 4 = slot-1 state, 5 = slot-1 count, 6 = transmit count. Offsets 0, 2, 3, 4 and 5 read back exactly what was written. Setup bit 0 drives `phy_reset`.
- R3: Slot states are encoded as EMPTY = 0, LOADED = 1 and PENDING = 2. On `frame_done`, the frame goes to slot 0 if slot 0 holds LOADED, otherwise to slot 1 if slot 1 holds LOADED. The chosen slot's count register takes `frame_len` (zero-extended) and its state becomes PENDING on that clock edge.
- R4: On `frame_done` with neither slot LOADED, the frame is dropped and no register changes.
- R5: `rx_ready` is high, combinationally, exactly when at least one slot state equals LOADED.
- R6: `rx_irq` is registered. After the edge at which the slot states change, it equals "either state equals PENDING" one clock later.
- R7: A write of a value from 64 to 1530 inclusive to offset 6 leaves that register at 0. `tx_irq` is high for exactly the one cycle after the write.
- R8: A nonzero write to offset 6 below 64 or above 1530 leaves the written value in the register and still pulses `tx_irq` for one cycle.
- R9: A write of 0 to offset 6 stores 0 and produces no `tx_irq` pulse.
- R10: In the management register, bit 1 is read-only and reflects `mdio_in`, registered one cycle. Software writes do not change it. Bits 0, 2 and 3 drive `mdio_out`, `mdio_oe` and `mdio_clk`.
- R11: Accesses at offset 7 or above read 0 and change no register. They raise `acc_err` for the one cycle after the access.
- R12: When a frame is accepted into a slot in the same cycle that software writes that slot's state or count, the frame update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Word offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from `acc_addr` |
| acc_err | output | 1 | One-cycle flag for an access to an unmapped offset |
| frame_done | input | 1 | Receive datapath finished a frame |
| frame_len | input | LW | Byte count of that frame |
| rx_ready | output | 1 | At least one slot armed |
| rx_irq | output | 1 | Level: a slot is pending |
| tx_irq | output | 1 | One-cycle pulse after a nonzero transmit count write |
| mdio_in | input | 1 | Management data from the PHY |
| mdio_out | output | 1 | Management data toward the PHY |
| mdio_oe | output | 1 | Management data output enable |
| mdio_clk | output | 1 | Management clock |
| phy_reset | output | 1 | PHY reset control |

## Verification
The bench arms one slot, then both, then neither. It checks that slot 0 always wins when both are armed. A design with the priority reversed, or one that fills an unarmed slot, would store the count in the wrong register. The transmit length check is probed at 63, 64, 1530 and 1531 and with a write of 0. A design off by one at either limit would clear a register it should keep, and one that treats 0 as a command would pulse `tx_irq`. The bench also checks the one-cycle lag of `rx_irq`, the read-only management input bit, a frame that collides with a software write to the same slot, and an unmapped write at offset 8. A design that decodes only the low address bits would alias offset 8 onto the setup register.

// File: rtl/dual_slot_rx_ctrl.sv
module dual_slot_rx_ctrl #(
  parameter int AW = 4,
  parameter int LW = 16,
  parameter int TX_MIN = 64,
  parameter int TX_MAX = 1530
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   acc_rdata,
  output logic          acc_err,
  input  logic          frame_done,
  input  logic [LW-1:0] frame_len,
  output logic          rx_ready,
  output logic          rx_irq,
  output logic          tx_irq,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe,
  output logic          mdio_clk,
  output logic          phy_reset
);
  localparam int NREG = 7;
  localparam logic [31:0] ST_LOADED  = 32'd1;
  localparam logic [31:0] ST_PENDING = 32'd2;

  logic [31:0] setup_q, mdio_q, st0_q, cnt0_q, st1_q, cnt1_q, txc_q;
  logic        rx_irq_q, tx_irq_q, acc_err_q;

  wire mapped   = 32'(acc_addr) < NREG;
  wire wr_en    = acc_valid && acc_write && mapped;
  wire ld0      = st0_q == ST_LOADED;
  wire ld1      = st1_q == ST_LOADED;
  wire take0    = frame_done && ld0;
  wire take1    = frame_done && !ld0 && ld1;
  wire pend     = (st0_q == ST_PENDING) || (st1_q == ST_PENDING);
  wire tx_wr    = wr_en && acc_addr == AW'(6);
  wire tx_nz    = acc_wdata != 32'd0;
  wire tx_legal = acc_wdata >= 32'(TX_MIN) && acc_wdata <= 32'(TX_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q   <= '0;
      mdio_q    <= '0;
      st0_q     <= '0;
      cnt0_q    <= '0;
      st1_q     <= '0;
      cnt1_q    <= '0;
      txc_q     <= '0;
      rx_irq_q  <= 1'b0;
      tx_irq_q  <= 1'b0;
      acc_err_q <= 1'b0;
    end else begin
      acc_err_q <= acc_valid && !mapped;
      tx_irq_q  <= tx_wr && tx_nz;
      rx_irq_q  <= pend;
      mdio_q[1] <= mdio_in;
      if (wr_en) begin
        case (acc_addr)
          AW'(0): setup_q <= acc_wdata;
          AW'(1): mdio_q  <= {acc_wdata[31:2], mdio_in, acc_wdata[0]};
          AW'(2): st0_q   <= acc_wdata;
          AW'(3): cnt0_q  <= acc_wdata;
          AW'(4): st1_q   <= acc_wdata;
          AW'(5): cnt1_q  <= acc_wdata;
          AW'(6): txc_q   <= (tx_nz && tx_legal) ? 32'd0 : acc_wdata;
          default: ;
        endcase
      end
      if (take0) begin
        st0_q  <= ST_PENDING;
        cnt0_q <= 32'(frame_len);
      end
      if (take1) begin
        st1_q  <= ST_PENDING;
        cnt1_q <= 32'(frame_len);
      end
    end
  end

  always_comb begin
    case (acc_addr)
      AW'(0):  acc_rdata = setup_q;
      AW'(1):  acc_rdata = mdio_q;
      AW'(2):  acc_rdata = st0_q;
      AW'(3):  acc_rdata = cnt0_q;
      AW'(4):  acc_rdata = st1_q;
      AW'(5):  acc_rdata = cnt1_q;
      AW'(6):  acc_rdata = txc_q;
      default: acc_rdata = '0;
    endcase
  end

  assign rx_ready  = ld0 || ld1;
  assign rx_irq    = rx_irq_q;
  assign tx_irq    = tx_irq_q;
  assign acc_err   = acc_err_q;
  assign mdio_out  = mdio_q[0];
  assign mdio_oe   = mdio_q[2];
  assign mdio_clk  = mdio_q[3];
  assign phy_reset = setup_q[0];
endmodule

module dual_slot_rx_ctrl_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic [31:0]   acc_wdata,
  input logic          frame_done,
  input logic [31:0]   st0_q,
  input logic [31:0]   st1_q,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          acc_err
);
  a_r3_slot0_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && st0_q == 32'd1 |=> st0_q == 32'd2);

  a_r4_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && st0_q != 32'd1 && st1_q != 32'd1 && !(acc_valid && acc_write)
    |=> $stable(st0_q) && $stable(st1_q));

  a_r6_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_q == 32'd2 || st1_q == 32'd2) |=> rx_irq);

  a_r6_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_q != 32'd2 && st1_q != 32'd2) |=> !rx_irq);

  a_r7_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(acc_valid && acc_write && acc_addr == AW'(6) && acc_wdata != 32'd0));

  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid && 32'(acc_addr) >= 7));
endmodule

bind dual_slot_rx_ctrl dual_slot_rx_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .frame_done(frame_done),
  .st0_q(st0_q), .st1_q(st1_q), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .acc_err(acc_err)
);

// File: tb/dual_slot_rx_ctrl_tb_top.sv
module dual_slot_rx_ctrl_tb_top;
  localparam int AW = 4;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic [31:0]   acc_rdata;
  logic          acc_err, frame_done = 1'b0, rx_ready, rx_irq, tx_irq;
  logic [LW-1:0] frame_len = '0;
  logic          mdio_in = 1'b0, mdio_out, mdio_oe, mdio_clk, phy_reset;
  int            n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  dual_slot_rx_ctrl #(.AW(AW), .LW(LW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic tx, output logic er);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = AW'(a); acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    tx = tx_irq; er = acc_err;
  endtask

  task automatic wrq(input int a, input logic [31:0] d);
    logic t, e;
    wr(a, d, t, e);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    acc_addr = AW'(a);
    #1 d = acc_rdata;
  endtask

  task automatic frame(input int len);
    @(negedge clk);
    frame_done = 1; frame_len = LW'(len);
    @(negedge clk);
    frame_done = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      chk("R1 reg after reset", (i == 1) ? (v & ~32'h2) : v, 0);
    end
    chk("R1 irqs/flags", {rx_irq, tx_irq, acc_err, rx_ready, phy_reset}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wrq(0, 32'h0000_0001); rd(0, v); chk("R2 setup", v, 1);
    chk("R2 phy_reset", phy_reset, 1);
    wrq(3, 32'hDEAD_0003); rd(3, v); chk("R2 count0", v, 32'hDEAD_0003);
    wrq(5, 32'h1234_5678); rd(5, v); chk("R2 count1", v, 32'h1234_5678);
    wrq(0, 0);             rd(0, v); chk("R2 setup clear", v, 0);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    wrq(2, 1); wrq(4, 1);
    chk("R5 ready both", rx_ready, 1);
    frame(100);
    chk("R6 irq lags", rx_irq, 0);
    @(negedge clk); chk("R6 irq high", rx_irq, 1);
    rd(2, v); chk("R3 slot0 pending", v, 2);
    rd(3, v); chk("R3 slot0 count", v, 100);
    rd(4, v); chk("R3 slot1 still loaded", v, 1);
    frame(222);
    rd(4, v); chk("R3 slot1 pending", v, 2);
    rd(5, v); chk("R3 slot1 count", v, 222);
    chk("R5 ready none", rx_ready, 0);
    frame(333);
    rd(3, v); chk("R4 count0 kept", v, 100);
    rd(5, v); chk("R4 count1 kept", v, 222);
    rd(2, v); chk("R4 state0 kept", v, 2);
    wrq(2, 0);
    chk("R6 still high one slot", rx_irq, 1);
    wrq(4, 0);
    chk("R6 lag on clear", rx_irq, 1);
    @(negedge clk); chk("R6 irq low", rx_irq, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wrq(4, 1);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = AW'(5); acc_wdata = 32'd7;
    frame_done = 1; frame_len = LW'(444);
    @(negedge clk);
    acc_valid = 0; acc_write = 0; frame_done = 0;
    rd(5, v); chk("R12 frame wins count", v, 444);
    rd(4, v); chk("R12 state pending", v, 2);
    wrq(4, 0);
  endtask

  task automatic t_tx;
    logic [31:0] v; logic t, e;
    wr(6, 64, t, e);   chk("R7 pulse 64", t, 1); rd(6, v); chk("R7 clear 64", v, 0);
    chk("R7 pulse one cycle", tx_irq, 0);
    wr(6, 1530, t, e); chk("R7 pulse 1530", t, 1); rd(6, v); chk("R7 clear 1530", v, 0);
    wr(6, 63, t, e);   chk("R8 pulse 63", t, 1); rd(6, v); chk("R8 keep 63", v, 63);
    wr(6, 1531, t, e); chk("R8 pulse 1531", t, 1); rd(6, v); chk("R8 keep 1531", v, 1531);
    wr(6, 0, t, e);    chk("R9 no pulse", t, 0); rd(6, v); chk("R9 zero", v, 0);
  endtask

  task automatic t_mdio;
    logic [31:0] v;
    mdio_in = 1;
    wrq(1, 32'h0000_000D);
    rd(1, v); chk("R10 mdio reg", v, 32'hF);
    chk("R10 pins", {mdio_clk, mdio_oe, mdio_out}, 3'b111);
    wrq(1, 32'h0000_0002); mdio_in = 0;
    @(negedge clk);
    rd(1, v); chk("R10 bit1 follows input", v, 0);
    chk("R10 pins low", {mdio_clk, mdio_oe, mdio_out}, 3'b000);
  endtask

  task automatic t_bad;
    logic [31:0] v; logic t, e;
    wrq(0, 32'h0000_00A0);
    wr(8, 32'hFFFF_FFFF, t, e); chk("R11 err pulse", e, 1);
    rd(0, v); chk("R11 no alias", v, 32'h0000_00A0);
    rd(7, v); chk("R11 read zero", v, 0);
    @(negedge clk); acc_valid = 1; acc_addr = AW'(15);
    @(negedge clk); acc_valid = 0; chk("R11 read err", acc_err, 1);
    @(negedge clk); chk("R11 err one cycle", acc_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_rx;
    t_collide;
    t_tx;
    t_mdio;
    t_bad;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule